// File: doc/BRIEF.md
# Ordered Lockable Memory Region Table

This block keeps a small table of protection entries. Each entry is written as two 32-bit words. The base word holds the region's start address, an enable flag and a lock flag. The attribute word holds a segment number, a 4-bit access-rights code and a 9-bit memory-type code. An entry's region covers the addresses from its own start up to, but not including, the start of the entry after it. The last entry's region runs to the top of the 32-bit address space. Software writes the entries in ascending start-address order.

A combinational lookup port takes an address and returns the rights and memory type of the region that contains it, together with a hit flag. A per-entry enable vector can be written as one register. It always shows the enable bits of the entries. A lock bit stays set until reset. While it is set, it freezes its own entry and also the start address of the next entry.

Top module: `mpu_region_table`

## Requirements
- R1: After reset every entry reads back as zero (base word 0, attribute word 0), `ena_q` is 0, and every lookup misses.
- R2: Base word layout: bit 0 enable, bit 1 lock, bits 31:5 start address. Attribute word layout: bits 4:0 segment, bits 11:8 rights, bits 20:12 memory type. Base bits 4:2 and attribute bits 7:5 and 31:21 are stored as zero whatever is written, and they read back as zero on `rd_w0`/`rd_w1`.
- R3: An entry write presented with `wr_en` high becomes visible on the read port and in lookups only after the next rising clock edge. Before that edge the old contents remain.
- R4: Bit i of `ena_q` equals the enable bit of entry i. Writing the entry's enable bit changes `ena_q[i]`, and writing `ena_wdata` through `ena_we` changes the entries' enable bits. If both write the same unlocked entry in one cycle, the entry write wins for that entry.
- R5: A set lock bit cannot be cleared by any write. Only reset releases it.
- R6: While entry i is locked, entry writes to i and enable-register writes to bit i are ignored.
- R7: While entry i-1 is locked, an entry write to i leaves its start address unchanged but updates its enable, lock, segment, rights and memory type.
- R8: A lookup returns `lk_hit`=1 with the rights and type of the highest-indexed enabled entry whose start is at or below `lk_addr[31:5]`. Address bits 4:0 take no part in the match.
- R9: If no enabled entry has a start at or below the address, `lk_hit` is 0 and `lk_rights` and `lk_mtype` are 0.
- R10: The highest enabled entry matches every address from its start up to 0xFFFFFFFF.
- R11: With parameter `LOCK_EN` = 0, the lock bit always reads as zero and never blocks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDXW | Index of the entry being written |
| wr_w0 | input | 32 | Base word to write |
| wr_w1 | input | 32 | Attribute word to write |
| ena_we | input | 1 | Enable-vector write strobe |
| ena_wdata | input | N | Enable-vector write data |
| ena_q | output | N | Enable bit of every entry |
| rd_idx | input | IDXW | Index of the entry to read |
| rd_w0 | output | 32 | Base word of the selected entry |
| rd_w1 | output | 32 | Attribute word of the selected entry |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup matched an enabled region |
| lk_rights | output | 4 | Rights of the matched region |
| lk_mtype | output | 9 | Memory type of the matched region |

## Verification
The bench attacks several region boundaries:
- the first byte of a start address;
- the last byte before the next start;
- addresses below every start;
- the very top of the address space.

A wrong comparison or the wrong priority direction would return the neighbouring region's attributes. Disabling an entry in the middle of the table checks that the lookup falls back to the entry below it rather than missing.

Lock handling is tested against both the locked entry and its successor. The checks show the start address staying frozen while the successor's other fields still change. The lock is also shown to survive clearing writes and to drop only at reset. A design that froze the whole successor, or let the enable register reach a locked entry, would read back different words.

A second instance built without locking confirms that the lock bit reads zero there.

// File: rtl/mpu_tbl_pkg.sv
package mpu_tbl_pkg;

    localparam int WORD_W   = 32;
    localparam int GRAN_W   = 5;
    localparam int START_W  = WORD_W - GRAN_W;
    localparam int SEG_W    = 5;
    localparam int RIGHTS_W = 4;
    localparam int MTYPE_W  = 9;

    typedef struct packed {
        logic [START_W-1:0]  start;
        logic                en;
        logic                lock;
        logic [SEG_W-1:0]    seg;
        logic [RIGHTS_W-1:0] rights;
        logic [MTYPE_W-1:0]  mtype;
    } mpu_entry_t;

    // Base word image: start | zero | lock | enable
    function automatic logic [WORD_W-1:0] pack_base(input mpu_entry_t e);
        return {e.start, 3'b000, e.lock, e.en};
    endfunction

    // Attribute word image: zero | type | rights | zero | segment
    function automatic logic [WORD_W-1:0] pack_attr(input mpu_entry_t e);
        return {11'b0, e.mtype, e.rights, 3'b000, e.seg};
    endfunction

endpackage

// File: rtl/mpu_tbl_regs.sv
module mpu_tbl_regs
    import mpu_tbl_pkg::*;
#(
    parameter int N       = 16,
    parameter bit LOCK_EN = 1'b1,
    localparam int IDXW   = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDXW-1:0]          wr_idx,
    input  logic [WORD_W-1:0]        wr_w0,
    input  logic [WORD_W-1:0]        wr_w1,
    input  logic                     ena_we,
    input  logic [N-1:0]             ena_wdata,
    output mpu_entry_t [N-1:0]       ent_q
);

    typedef struct packed {
        mpu_entry_t [N-1:0] ent;
    } tbl_t;

    tbl_t         st_d, st_q;
    logic [N-1:0] locked;
    logic [N-1:0] pred_locked;
    logic         unused_mbz;

    assign unused_mbz = ^{wr_w0[4:2], wr_w1[7:5], wr_w1[31:21]};

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            locked[i] = st_q.ent[i].lock;
        end
        pred_locked = {locked[N-2:0], 1'b0};

        if (ena_we) begin
            for (int i = 0; i < N; i++) begin
                if (!locked[i]) begin
                    st_d.ent[i].en = ena_wdata[i];
                end
            end
        end

        for (int i = 0; i < N; i++) begin
            if (wr_en && (wr_idx == IDXW'(i)) && !locked[i]) begin
                st_d.ent[i].en     = wr_w0[0];
                st_d.ent[i].lock   = wr_w0[1] & LOCK_EN;
                st_d.ent[i].seg    = wr_w1[4:0];
                st_d.ent[i].rights = wr_w1[11:8];
                st_d.ent[i].mtype  = wr_w1[20:12];
                if (!pred_locked[i]) begin
                    st_d.ent[i].start = wr_w0[WORD_W-1:GRAN_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_q = st_q.ent;

endmodule

// File: rtl/mpu_tbl_lookup.sv
module mpu_tbl_lookup
    import mpu_tbl_pkg::*;
#(
    parameter int N     = 16,
    localparam int IDXW = $clog2(N)
) (
    input  mpu_entry_t [N-1:0]   ents,
    input  logic [START_W-1:0]   blk,
    output logic                 hit,
    output logic [IDXW-1:0]      idx,
    output logic [RIGHTS_W-1:0]  rights,
    output logic [MTYPE_W-1:0]   mtype
);

    logic [N-1:0] cand;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cand[i] = ents[i].en && (ents[i].start <= blk);
        end
    end

    // Later index overrides earlier: highest candidate wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                hit = 1'b1;
                idx = IDXW'(i);
            end
        end
        rights = hit ? ents[idx].rights : '0;
        mtype  = hit ? ents[idx].mtype  : '0;
    end

endmodule

// File: rtl/mpu_region_table.sv
module mpu_region_table
    import mpu_tbl_pkg::*;
#(
    parameter int N       = 16,
    parameter bit LOCK_EN = 1'b1,
    localparam int IDXW   = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [31:0]          wr_w0,
    input  logic [31:0]          wr_w1,
    input  logic                 ena_we,
    input  logic [N-1:0]         ena_wdata,
    output logic [N-1:0]         ena_q,
    input  logic [IDXW-1:0]      rd_idx,
    output logic [31:0]          rd_w0,
    output logic [31:0]          rd_w1,
    input  logic [31:0]          lk_addr,
    output logic                 lk_hit,
    output logic [3:0]           lk_rights,
    output logic [8:0]           lk_mtype
);

    mpu_entry_t [N-1:0] ent_q;
    logic [IDXW-1:0]    lk_idx;
    logic               unused_low;

    assign unused_low = ^lk_addr[GRAN_W-1:0];

    mpu_tbl_regs #(.N(N), .LOCK_EN(LOCK_EN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_w0     (wr_w0),
        .wr_w1     (wr_w1),
        .ena_we    (ena_we),
        .ena_wdata (ena_wdata),
        .ent_q     (ent_q)
    );

    mpu_tbl_lookup #(.N(N)) u_lookup (
        .ents   (ent_q),
        .blk    (lk_addr[WORD_W-1:GRAN_W]),
        .hit    (lk_hit),
        .idx    (lk_idx),
        .rights (lk_rights),
        .mtype  (lk_mtype)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ena_q[i] = ent_q[i].en;
        end
        rd_w0 = pack_base(ent_q[rd_idx]);
        rd_w1 = pack_attr(ent_q[rd_idx]);
    end

endmodule

// File: rtl/mpu_region_table_chk.sv
module mpu_region_table_chk
    import mpu_tbl_pkg::*;
#(
    parameter int N       = 16,
    parameter bit LOCK_EN = 1'b1,
    localparam int IDXW   = $clog2(N)
) (
    input logic                 clk,
    input logic                 rst_n,
    input mpu_entry_t [N-1:0]   ents,
    input logic [START_W-1:0]   lk_blk,
    input logic                 lk_hit,
    input logic [IDXW-1:0]      lk_idx,
    input logic [3:0]           lk_rights,
    input logic [8:0]           lk_mtype,
    input logic [31:0]          rd_w0,
    input logic [31:0]          rd_w1
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ents[i].lock |=> ents[i].lock);

        p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ents[i].lock |=> $stable(ents[i]));

        if (i > 0) begin : g_succ
            p_succ_start_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ents[i-1].lock |=> $stable(ents[i].start));
        end

        if (!LOCK_EN) begin : g_nolock
            p_lock_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !ents[i].lock);
        end
    end

    p_hit_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (ents[lk_idx].en && (ents[lk_idx].start <= lk_blk)));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_rights == '0 && lk_mtype == '0));

    p_mbz_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_w0[4:2] == 3'b000) && (rd_w1[7:5] == 3'b000) && (rd_w1[31:21] == '0));

endmodule

bind mpu_region_table mpu_region_table_chk #(.N(N), .LOCK_EN(LOCK_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ents      (ent_q),
    .lk_blk    (lk_addr[31:5]),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_rights (lk_rights),
    .lk_mtype  (lk_mtype),
    .rd_w0     (rd_w0),
    .rd_w1     (rd_w1)
);

// File: tb/tb_mpu_region_table.sv
module tb_mpu_region_table;

    localparam int CLK_P = 10;
    localparam int N     = 16;
    localparam int IDXW  = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [IDXW-1:0] wr_idx = '0;
    logic [31:0]     wr_w0 = '0, wr_w1 = '0;
    logic            ena_we = 1'b0;
    logic [N-1:0]    ena_wdata = '0;
    logic [IDXW-1:0] rd_idx = '0;
    logic [31:0]     lk_addr = '0;

    logic [N-1:0]    ena_q, nl_ena_q;
    logic [31:0]     rd_w0, rd_w1, nl_rd_w0, nl_rd_w1;
    logic            lk_hit, nl_hit;
    logic [3:0]      lk_rights, nl_rights;
    logic [8:0]      lk_mtype, nl_mtype;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    mpu_region_table #(.N(N), .LOCK_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_w0(wr_w0), .wr_w1(wr_w1), .ena_we(ena_we), .ena_wdata(ena_wdata),
        .ena_q(ena_q), .rd_idx(rd_idx), .rd_w0(rd_w0), .rd_w1(rd_w1),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_rights(lk_rights), .lk_mtype(lk_mtype)
    );

    mpu_region_table #(.N(N), .LOCK_EN(1'b0)) dut_nl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_w0(wr_w0), .wr_w1(wr_w1), .ena_we(ena_we), .ena_wdata(ena_wdata),
        .ena_q(nl_ena_q), .rd_idx(rd_idx), .rd_w0(nl_rd_w0), .rd_w1(nl_rd_w1),
        .lk_addr(lk_addr), .lk_hit(nl_hit), .lk_rights(nl_rights), .lk_mtype(nl_mtype)
    );

    // Behavioural reference model of the locking table
    logic [26:0] m_start [N];
    bit          m_en    [N];
    bit          m_lock  [N];
    logic [4:0]  m_seg   [N];
    logic [3:0]  m_rt    [N];
    logic [8:0]  m_mt    [N];

    function automatic logic [31:0] mk_w0(input logic [31:0] a, input bit lk, input bit en);
        return {a[31:5], 3'b000, lk, en};
    endfunction

    function automatic logic [31:0] mk_w1(input int seg, input int rt, input int mt);
        return (32'(mt & 9'h1FF) << 12) | (32'(rt & 4'hF) << 8) | 32'(seg & 5'h1F);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clock();
        bit snap [N];
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_start[i] = '0; m_en[i] = 0; m_lock[i] = 0;
                m_seg[i] = '0; m_rt[i] = '0; m_mt[i] = '0;
            end
        end else begin
            for (int i = 0; i < N; i++) snap[i] = m_lock[i];
            if (ena_we) begin
                for (int i = 0; i < N; i++) if (!snap[i]) m_en[i] = ena_wdata[i];
            end
            if (wr_en) begin
                int k = int'(wr_idx);
                if (!snap[k]) begin
                    m_en[k]   = wr_w0[0];
                    m_lock[k] = wr_w0[1];
                    m_seg[k]  = wr_w1[4:0];
                    m_rt[k]   = wr_w1[11:8];
                    m_mt[k]   = wr_w1[20:12];
                    if (k == 0) m_start[k] = wr_w0[31:5];
                    else if (!snap[k-1]) m_start[k] = wr_w0[31:5];
                end
            end
        end
    endtask

    task automatic compare_all();
        int ri = int'(rd_idx);
        logic [N-1:0] ev;
        bit ehit = 0;
        logic [3:0] ert = '0;
        logic [8:0] emt = '0;
        for (int i = 0; i < N; i++) ev[i] = m_en[i];
        for (int i = N-1; i >= 0; i--) begin
            if (!ehit && m_en[i] && m_start[i] <= lk_addr[31:5]) begin
                ehit = 1; ert = m_rt[i]; emt = m_mt[i];
            end
        end
        chk("R2 model rd_w0", rd_w0, {m_start[ri], 3'b000, m_lock[ri], m_en[ri]});
        chk("R2 model rd_w1", rd_w1, {11'b0, m_mt[ri], m_rt[ri], 3'b000, m_seg[ri]});
        chk("R4 model ena_q", 32'(ena_q), 32'(ev));
        chk("R8 model hit", 32'(lk_hit), 32'(ehit));
        chk("R8 model rights", 32'(lk_rights), 32'(ert));
        chk("R8 model mtype", 32'(lk_mtype), 32'(emt));
    endtask

    task automatic tick();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int idx, input logic [31:0] w0, input logic [31:0] w1);
        wr_en = 1; wr_idx = IDXW'(idx); wr_w0 = w0; wr_w1 = w1;
        tick();
        wr_en = 0;
    endtask

    task automatic ena_wr(input logic [N-1:0] v);
        ena_we = 1; ena_wdata = v;
        tick();
        ena_we = 0;
    endtask

    task automatic look(input string tag, input logic [31:0] a, input bit h, input int rt, input int mt);
        lk_addr = a;
        #1;
        chk(tag, 32'(lk_hit), 32'(h));
        chk(tag, 32'(lk_rights), 32'(rt));
        chk(tag, 32'(lk_mtype), 32'(mt));
    endtask

    task automatic rd(input int idx);
        rd_idx = IDXW'(idx);
        #1;
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        rd(0);
        chk("R1 rd_w0", rd_w0, 32'h0);
        chk("R1 rd_w1", rd_w1, 32'h0);
        chk("R1 ena_q", 32'(ena_q), 32'h0);
        look("R1 miss", 32'h0000_0000, 0, 0, 0);

        // R2 MBZ fields discarded
        wr(0, mk_w0(32'h1000, 0, 1) | 32'h1C, mk_w1(1, 1, 'h011) | 32'hFFE0_00E0);
        rd(0);
        chk("R2 base", rd_w0, mk_w0(32'h1000, 0, 1));
        chk("R2 attr", rd_w1, mk_w1(1, 1, 'h011));

        // R3 write timing
        rd(1);
        wr_en = 1; wr_idx = 1; wr_w0 = mk_w0(32'h2000, 0, 1); wr_w1 = mk_w1(2, 2, 'h022);
        #1;
        chk("R3 before edge", rd_w0, 32'h0);
        tick();
        wr_en = 0;
        chk("R3 after edge", rd_w0, mk_w0(32'h2000, 0, 1));

        wr(2, mk_w0(32'h3000, 0, 1), mk_w1(3, 3, 'h033));
        wr(3, mk_w0(32'h4000, 0, 1), mk_w1(4, 4, 'h044));
        wr(15, mk_w0(32'hF000_0000, 0, 1), mk_w1(15, 15, 'h1FF));

        look("R9 below all", 32'h0000_0FFF, 0, 0, 0);
        look("R8 first byte", 32'h0000_1000, 1, 1, 'h011);
        look("R8 last byte before next", 32'h0000_2FFF, 1, 2, 'h022);
        look("R8 low bits ignored", 32'h0000_301F, 1, 3, 'h033);
        look("R8 gap to disabled", 32'hEFFF_FFFF, 1, 4, 'h044);
        look("R10 top of space", 32'hFFFF_FFFF, 1, 15, 'h1FF);

        // R4 enable register mirror
        ena_wr(16'h800B);
        chk("R4 ena_q write", 32'(ena_q), 32'h800B);
        rd(2);
        chk("R4 entry enable cleared", 32'(rd_w0[0]), 32'h0);
        look("R8 disabled falls back", 32'h0000_3500, 1, 2, 'h022);
        wr(2, mk_w0(32'h3000, 0, 1), mk_w1(3, 3, 'h033));
        chk("R4 entry write reflects", 32'(ena_q), 32'h800F);

        // R5 / R6 lock entry 1
        wr(1, mk_w0(32'h2000, 1, 1), mk_w1(2, 2, 'h022));
        rd(1);
        chk("R5 lock set", rd_w0, mk_w0(32'h2000, 1, 1));
        wr(1, mk_w0(32'h2800, 0, 0), mk_w1(9, 9, 'h099));
        chk("R6 base frozen", rd_w0, mk_w0(32'h2000, 1, 1));
        chk("R6 attr frozen", rd_w1, mk_w1(2, 2, 'h022));
        ena_wr(16'h800D);
        chk("R6 ena ignored on locked", 32'(ena_q), 32'h800F);

        // R7 successor start frozen, others writable
        wr(2, mk_w0(32'h3800, 0, 1), mk_w1(5, 6, 'h066));
        rd(2);
        chk("R7 start frozen", rd_w0, mk_w0(32'h3000, 0, 1));
        chk("R7 attr updated", rd_w1, mk_w1(5, 6, 'h066));
        look("R7 lookup new rights", 32'h0000_3000, 1, 6, 'h066);
        rd(1);
        chk("R5 lock still set", 32'(rd_w0[1]), 32'h1);

        // R4 simultaneous write: entry write wins
        ena_we = 1; ena_wdata = '0;
        wr(3, mk_w0(32'h4000, 0, 1), mk_w1(4, 4, 'h044));
        ena_we = 0;
        chk("R4 entry write wins", 32'(ena_q), 32'h000A);

        // Reset clears lock
        rst_n = 0;
        tick();
        rst_n = 1;
        tick();
        rd(1);
        chk("R5 reset releases lock", rd_w0, 32'h0);
        chk("R1 ena_q after reset", 32'(ena_q), 32'h0);
        wr(1, mk_w0(32'h2400, 0, 1), mk_w1(1, 1, 'h001));
        chk("R5 writable after reset", rd_w0, mk_w0(32'h2400, 0, 1));

        // R11 locking disabled instance
        wr(4, mk_w0(32'h8000, 1, 1), mk_w1(2, 2, 'h002));
        rd(4);
        chk("R11 lock reads zero", nl_rd_w0, mk_w0(32'h8000, 0, 1));
        chk("R5 locking instance holds lock", rd_w0, mk_w0(32'h8000, 1, 1));
        wr(4, mk_w0(32'h9000, 0, 1), mk_w1(3, 3, 'h003));
        chk("R11 rewrite accepted", nl_rd_w0, mk_w0(32'h9000, 0, 1));
        chk("R11 rewrite attr", nl_rd_w1, mk_w1(3, 3, 'h003));
        wr(5, mk_w0(32'hA000, 0, 1), mk_w1(7, 7, 'h007));
        rd(5);
        chk("R11 successor start writable", nl_rd_w0, mk_w0(32'hA000, 0, 1));
        chk("R7 successor start held", rd_w0, mk_w0(32'h0000, 0, 1));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule